// File: doc/BRIEF.md
# Signed-Magnitude Adder/Subtractor

This block adds or subtracts two numbers held in signed-magnitude form: each operand is an unsigned magnitude of `WIDTH` bits with a separate sign bit. A start strobe latches both operands and the operation select. The block then runs a short sequence on one shared adder and returns a signed-magnitude result, an add-overflow flag and a one-cycle done pulse.

The sign bits and the operation select decide whether the magnitudes are added or subtracted. If the signs differ, the effective operation is flipped. A subtraction is done by adding the two's complement of the second magnitude. The carry out of that sum shows which magnitude is larger. When the second magnitude is the larger one, one extra cycle complements the result and flips its sign. A difference of zero always comes back with a positive sign.

The block fits a small sequential datapath that hands out work with a strobe and waits for done. The result outputs stay unchanged from the done pulse until the next operation is accepted.

Top module: `smag_addsub`

## Requirements
- R1: The magnitudes are added when the effective operation is an add. The effective operation is an add when `op_sub_i` XOR `a_sign_i` XOR `b_sign_i` is 0, where `op_sub_i`=0 means add and `op_sub_i`=1 means subtract. The result magnitude is (A+B) mod 2^WIDTH and the result sign is `a_sign_i`.
- R2: On a magnitude add, `ovf_o` equals the carry out of the WIDTH-bit sum A+B.
- R3: The magnitudes are subtracted when the effective operation is a subtract, that is when the XOR in R1 is 1. If A ≥ B, the result magnitude is A−B and the sign is `a_sign_i`.
- R4: On a magnitude subtract with A < B, the result magnitude is B−A and the sign is the inverse of `a_sign_i`.
- R5: On a magnitude subtract, `ovf_o` is 0.
- R6: A magnitude subtract that gives zero returns sign 0, so no negative zero is produced.
- R7: `done_o` goes high after one rising edge beyond the edge that accepts start. When the correction of R4 is needed it takes two such edges. `done_o` stays high for exactly one cycle, and the outputs are valid while it is high.
- R8: A start strobe that arrives while an operation is in progress, or in its done cycle, is ignored. The result of the running operation is unchanged, and no extra done pulse follows.
- R9: After synchronous reset, `done_o`, `ovf_o`, `res_sign_o` and `res_mag_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| op_sub_i | input | 1 | 0 = add, 1 = subtract |
| a_sign_i | input | 1 | Sign of operand A (1 = negative) |
| a_mag_i | input | WIDTH | Magnitude of operand A |
| b_sign_i | input | 1 | Sign of operand B (1 = negative) |
| b_mag_i | input | WIDTH | Magnitude of operand B |
| res_sign_o | output | 1 | Result sign |
| res_mag_o | output | WIDTH | Result magnitude |
| ovf_o | output | 1 | Add-overflow flag |
| done_o | output | 1 | One-cycle result-ready pulse |

## Verification
Two situations are hard to reach. One is a strobe that lands while the block is busy. The other is a subtraction of equal magnitudes with a negative A, which is the only path that can produce a negative zero. Random stimulus almost never produces either, so directed cases raise start again in the cycle after acceptance, and subtract equal magnitudes under every sign and operation combination. The random stream narrows the magnitude range for part of the run. This makes equal and near-equal operands frequent, so the borrow correction and the zero-sign rule are exercised often.

// File: rtl/smag_pkg.sv
// Shared types for the signed-magnitude adder/subtractor.
// Assumes: nothing beyond the standard language.
package smag_pkg;

    // Sequencer states: idle, adder pass, borrow correction, result ready.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CALC = 2'd1,
        ST_FIX  = 2'd2,
        ST_DONE = 2'd3
    } smag_state_t;

    // Effective magnitude operation: 1 means subtract the magnitudes.
    function automatic logic eff_subtract(input logic op_sub,
                                          input logic sa,
                                          input logic sb);
        return op_sub ^ sa ^ sb;
    endfunction

endpackage

// File: rtl/smag_ripple_adder.sv
// WIDTH-bit ripple-carry adder built from full-adder cells.
// Assumes: the caller supplies the possibly complemented B operand and the carry-in.
module smag_ripple_adder #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);

    logic [WIDTH:0] carry;

    assign carry[0] = cin_i;

    // One full-adder cell per bit; the carries ripple upward.
    for (genvar i = 0; i < WIDTH; i++) begin : g_fa
        assign sum_o[i]   = a_i[i] ^ b_i[i] ^ carry[i];
        assign carry[i+1] = (a_i[i] & b_i[i]) | (carry[i] & (a_i[i] ^ b_i[i]));
    end

    assign cout_o = carry[WIDTH];

endmodule

// File: rtl/smag_datapath.sv
// Operand and result registers, complementer and carry flip-flop.
// Assumes: at most one of load_en, calc_en and fix_en is high in a cycle.
module smag_datapath #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic             calc_en,
    input  logic             fix_en,
    input  logic             done_i,
    input  logic             op_sub_i,
    input  logic             a_sign_i,
    input  logic [WIDTH-1:0] a_mag_i,
    input  logic             b_sign_i,
    input  logic [WIDTH-1:0] b_mag_i,
    output logic             eff_sub_o,
    output logic             carry_o,
    output logic             sign_o,
    output logic [WIDTH-1:0] mag_o,
    output logic             ovf_o
);
    import smag_pkg::*;

    logic [WIDTH-1:0] acc_q;
    logic [WIDTH-1:0] opb_q;
    logic             sign_q;
    logic             sub_q;
    logic             e_q;
    logic             avf_q;
    logic [WIDTH-1:0] opb_sel;
    logic [WIDTH-1:0] sum;
    logic             cout;
    logic [WIDTH-1:0] acc_neg;

    // Complementer: pass B for an add, invert B for a subtract.
    assign opb_sel = opb_q ^ {WIDTH{sub_q}};
    // Two's complement of the accumulator for the borrow correction.
    assign acc_neg = (~acc_q) + WIDTH'(1);

    smag_ripple_adder #(.WIDTH(WIDTH)) u_adder (
        .a_i    (acc_q),
        .b_i    (opb_sel),
        .cin_i  (sub_q),
        .sum_o  (sum),
        .cout_o (cout)
    );

    // Register update: load operands, take the adder result, or correct.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            opb_q  <= '0;
            sign_q <= 1'b0;
            sub_q  <= 1'b0;
            e_q    <= 1'b0;
            avf_q  <= 1'b0;
        end else if (load_en) begin
            acc_q  <= a_mag_i;
            opb_q  <= b_mag_i;
            sign_q <= a_sign_i;
            sub_q  <= eff_subtract(op_sub_i, a_sign_i, b_sign_i);
            e_q    <= 1'b0;
            avf_q  <= 1'b0;
        end else if (calc_en) begin
            acc_q <= sum;
            e_q   <= cout;
            avf_q <= sub_q ? 1'b0 : cout;
            if (sub_q && cout && (sum == '0)) begin
                sign_q <= 1'b0;
            end
        end else if (fix_en) begin
            acc_q  <= acc_neg;
            sign_q <= ~sign_q;
        end
    end

    assign eff_sub_o = sub_q;
    assign carry_o   = cout;
    assign sign_o    = sign_q;
    assign mag_o     = acc_q;
    assign ovf_o     = avf_q;

    AST_SUB_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (calc_en && sub_q) |=> !avf_q);  // R5
    AST_ADD_OVF_IS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (calc_en && !sub_q) |=> (avf_q == e_q));  // R2
    AST_NO_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && sub_q && (acc_q == '0)) |-> !sign_q);  // R6
    AST_OPB_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(opb_q));  // R8

endmodule

// File: rtl/smag_ctrl.sv
// Sequencer: accepts start when idle, runs one adder pass, adds a
// correction cycle after a borrow, then pulses done for one cycle.
// Assumes: eff_sub_i and carry_i come from the datapath in the same cycle.
module smag_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic eff_sub_i,
    input  logic carry_i,
    output logic load_en,
    output logic calc_en,
    output logic fix_en,
    output logic done_o
);
    import smag_pkg::*;

    smag_state_t state_q;
    smag_state_t state_d;

    // Next-state choice; start counts only in the idle state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_CALC;
            ST_CALC: state_d = (eff_sub_i && !carry_i) ? ST_FIX : ST_DONE;
            ST_FIX:  state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign load_en = (state_q == ST_IDLE) && start_i;
    assign calc_en = (state_q == ST_CALC);
    assign fix_en  = (state_q == ST_FIX);
    assign done_o  = (state_q == ST_DONE);

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);  // R7
    AST_BORROW_FIX: assert property (@(posedge clk) disable iff (!rst_n)
        (calc_en && eff_sub_i && !carry_i) |=> fix_en);  // R4
    AST_NO_BORROW_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (calc_en && !(eff_sub_i && !carry_i)) |=> done_o);  // R7
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> !calc_en);  // R8

endmodule

// File: rtl/smag_addsub.sv
// Top of the signed-magnitude adder/subtractor: a sequencer plus a datapath
// that share one adder.
// Assumes: operands are sampled only on the clock edge that accepts start.
module smag_addsub #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             op_sub_i,
    input  logic             a_sign_i,
    input  logic [WIDTH-1:0] a_mag_i,
    input  logic             b_sign_i,
    input  logic [WIDTH-1:0] b_mag_i,
    output logic             res_sign_o,
    output logic [WIDTH-1:0] res_mag_o,
    output logic             ovf_o,
    output logic             done_o
);

    logic load_en;
    logic calc_en;
    logic fix_en;
    logic eff_sub;
    logic carry;

    smag_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .eff_sub_i (eff_sub),
        .carry_i   (carry),
        .load_en   (load_en),
        .calc_en   (calc_en),
        .fix_en    (fix_en),
        .done_o    (done_o)
    );

    smag_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .calc_en   (calc_en),
        .fix_en    (fix_en),
        .done_i    (done_o),
        .op_sub_i  (op_sub_i),
        .a_sign_i  (a_sign_i),
        .a_mag_i   (a_mag_i),
        .b_sign_i  (b_sign_i),
        .b_mag_i   (b_mag_i),
        .eff_sub_o (eff_sub),
        .carry_o   (carry),
        .sign_o    (res_sign_o),
        .mag_o     (res_mag_o),
        .ovf_o     (ovf_o)
    );

endmodule

// File: tb/smag_addsub_tb.sv
module smag_addsub_tb;
    localparam int W = 8;
    localparam int MAXV = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         op_sub_i = 1'b0;
    logic         a_sign_i = 1'b0;
    logic [W-1:0] a_mag_i = '0;
    logic         b_sign_i = 1'b0;
    logic [W-1:0] b_mag_i = '0;
    logic         res_sign_o;
    logic [W-1:0] res_mag_o;
    logic         ovf_o;
    logic         done_o;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit finished = 0;

    always #10 clk = ~clk;  // 50 MHz

    smag_addsub #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_sub_i(op_sub_i),
        .a_sign_i(a_sign_i), .a_mag_i(a_mag_i), .b_sign_i(b_sign_i),
        .b_mag_i(b_mag_i), .res_sign_o(res_sign_o), .res_mag_o(res_mag_o),
        .ovf_o(ovf_o), .done_o(done_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    // Watchdog: an expired run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
            summary();
        end
    end

    // Expected result from the requirements: {fix, ovf, sign, mag}.
    function automatic logic [W+2:0] model(input logic op, input logic sa, input int a,
                                           input logic sb, input int b);
        logic es;
        int s;
        es = op ^ sa ^ sb;
        if (!es) begin
            s = a + b;
            return {1'b0, s[W], sa, s[W-1:0]};
        end else if (a >= b) begin
            s = a - b;
            return {1'b0, 1'b0, (a == b) ? 1'b0 : sa, s[W-1:0]};
        end else begin
            s = b - a;
            return {1'b1, 1'b0, ~sa, s[W-1:0]};
        end
    endfunction

    // One operation; optionally raise start again while busy (R8).
    task automatic run_op(input logic op, input logic sa, input int a,
                          input logic sb, input int b, input bit poke);
        logic [W+2:0] e;
        int n;
        bit es;
        e  = model(op, sa, a, sb, b);
        es = op ^ sa ^ sb;
        @(negedge clk);
        op_sub_i = op; a_sign_i = sa; a_mag_i = W'(a); b_sign_i = sb; b_mag_i = W'(b);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        if (poke) begin
            op_sub_i = ~op; a_sign_i = ~sa; a_mag_i = ~W'(a); b_mag_i = W'(b) + W'(3);
            start_i = 1'b1;
        end
        while (!done_o && n < 8) begin
            @(negedge clk);
            n++;
            if (poke) start_i = 1'b1;
        end
        check(e[W+2] ? "R4 latency" : "R7 latency", n, e[W+2] ? 2 : 1);
        check(!es ? "R1 magnitude" : (e[W+2] ? "R4 magnitude" : "R3 magnitude"),
              int'(res_mag_o), int'(e[W-1:0]));
        check((es && a == b) ? "R6 sign" : (!es ? "R1 sign" : (e[W+2] ? "R4 sign" : "R3 sign")),
              int'(res_sign_o), int'(e[W]));
        check(es ? "R5 overflow" : "R2 overflow", int'(ovf_o), int'(e[W+1]));
        start_i = 1'b0;
        @(negedge clk);
        check("R7 done width", int'(done_o), 0);
        if (poke) begin
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                check("R8 no extra done", int'(done_o), 0);
            end
            check("R8 result kept", int'(res_mag_o), int'(e[W-1:0]));
        end
    endtask

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        check("R9 done", int'(done_o), 0);
        check("R9 ovf", int'(ovf_o), 0);
        check("R9 sign", int'(res_sign_o), 0);
        check("R9 mag", int'(res_mag_o), 0);
        rst_n = 1'b1;
        // Directed corners
        run_op(0, 0, 3, 0, 2, 0);          // R1 plain add
        run_op(0, 1, MAXV, 1, MAXV, 0);    // R2 overflow with negative sign
        run_op(0, 0, 8, 1, 3, 0);          // R3 A>=B
        run_op(0, 1, 8, 1, 3, 0);          // R1 via two negatives
        run_op(1, 0, 8, 1, 3, 0);          // R1 subtract with unequal signs
        run_op(1, 1, 8, 1, 3, 0);          // R3
        run_op(0, 0, 3, 1, 8, 0);          // R4 A<B
        run_op(1, 1, 0, 1, MAXV, 0);       // R4 extreme
        for (int i = 0; i < 8; i++)        // R6 equal magnitudes, all sign/op mixes
            run_op(i[0], i[1], 77, i[2], 77, 0);
        run_op(0, 0, 0, 0, 0, 0);          // zero operands
        run_op(1, 0, 5, 0, 9, 1);          // R8 start while correcting
        run_op(0, 1, 200, 1, 100, 1);      // R8 start while adding
        // Random mix, half of it with narrow magnitudes
        for (int i = 0; i < 400; i++) begin
            int a, b;
            if (i % 2 == 0) begin
                a = $urandom_range(MAXV);
                b = $urandom_range(MAXV);
            end else begin
                a = $urandom_range(3);
                b = $urandom_range(3);
            end
            run_op(1'($urandom_range(1)), 1'($urandom_range(1)), a,
                   1'($urandom_range(1)), b, (i % 37) == 5);
        end
        summary();
    end
endmodule